// File: doc/BRIEF.md
# Quadword Load/Store Cracker

A decode-stage sequencer that turns each 16-byte memory operation into two doubleword micro-ops. It handles the plain load, plain store, reserve load and conditional store forms. Any other operation passes through unchanged as one micro-op. The two micro-ops of a pair go to the same register pair and to two consecutive doublewords. The endianness flag decides which register of the even/odd pair is written first. Memory is always touched in increasing address order.

The block also screens the operation before splitting it. A reserve load whose base or index register overlaps its target is flagged illegal. In little-endian mode, a 16-byte load that is not 16-byte aligned raises an alignment exception. In both cases a single flagged micro-op is emitted instead of a pair. Upstream is held off until the second micro-op of a pair has been accepted. A flush drops a pending second micro-op and returns the sequencer to idle.

Top module: `qw_cracker`

## Requirements
- R1: An operation of kind 0 (not quadword) is emitted as one micro-op with the same kind, registers and address. Its repeat, second, inhibit and exception flags are clear, and in_ready_o equals out_ready_i.
- R2: Each operation of kind 1 (quad load), 2 (quad store), 3 (quad reserve load) or 4 (quad conditional store) that is not flagged is emitted as two micro-ops. Both have repeat set, and only the second has second set. The second micro-op is offered in the cycle after the first is accepted.
- R3: With le_i=1, the first micro-op carries the target register with bit 0 forced to 1. The second carries the target register with bit 0 as given.
- R4: With le_i=0, the first micro-op carries the target register with bit 0 as given. The second carries it with bit 0 forced to 1.
- R5: The first micro-op carries the operand address. The second carries the operand address plus 8.
- R6: A kind 3 operation whose ra or rb equals rt is emitted as one micro-op with out_illegal_o=1 and repeat clear, and is consumed in one handshake.
- R7: With le_i=1, a kind 1 or kind 3 operation whose address bits [3:0] are not zero is emitted as one micro-op with out_align_exc_o=1 and repeat clear. With le_i=0, or for stores, no alignment check applies. R6 takes priority over R7.
- R8: out_irq_inhibit_o is 1 on the second micro-op of a pair and 0 on every other micro-op.
- R9: in_ready_o is 0 while the first micro-op of a pair is offered, even when out_ready_i is 1. It equals out_ready_i while the second micro-op is offered.
- R10: While flush_i is 1, out_valid_o and in_ready_o are 0. In the cycle after a flush the sequencer is idle, so a still-valid quadword input is offered again as a first micro-op.
- R11: After reset the sequencer is idle: out_valid_o follows in_valid_i, and with no input nothing is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Abort a pending pair, return to idle |
| in_valid_i | input | 1 | Decoded operation valid |
| in_ready_o | output | 1 | Operation consumed |
| in_kind_i | input | 3 | Operation kind (0 other, 1 qload, 2 qstore, 3 qreserve, 4 qcond) |
| in_rt_i | input | REG_W | Target/source register |
| in_ra_i | input | REG_W | Base register |
| in_rb_i | input | REG_W | Index register |
| in_addr_i | input | ADDR_W | Operand effective address |
| in_le_i | input | 1 | Little-endian mode |
| out_valid_o | output | 1 | Micro-op valid |
| out_ready_i | input | 1 | Micro-op accepted downstream |
| out_kind_o | output | 3 | Operation kind |
| out_rt_o | output | REG_W | Adjusted register number |
| out_ra_o | output | REG_W | Base register |
| out_rb_o | output | REG_W | Index register |
| out_addr_o | output | ADDR_W | Doubleword address |
| out_repeat_o | output | 1 | Part of a split pair |
| out_second_o | output | 1 | Second micro-op of a pair |
| out_irq_inhibit_o | output | 1 | No asynchronous or trace interrupt before this micro-op |
| out_illegal_o | output | 1 | Illegal register overlap |
| out_align_exc_o | output | 1 | Alignment exception |

## Verification
The assertions check, on every cycle, several structural properties. The second flag never appears without repeat. An accepted first micro-op is followed by its second unless a flush intervenes. A flagged micro-op is never split, and the two exception flags are never both set. Upstream is held while a first micro-op is offered, and a flush always leaves the sequencer idle. The pairs register stays inside the target's even/odd pair. Only the bench's scenarios can show the actual values: the register order under each endianness, the +8 address, which forms are flagged and when alignment is enforced, the inhibit placement, and a first micro-op re-offered after a flush or held under backpressure.

// File: rtl/qw_pkg.sv
package qw_pkg;
  typedef enum logic [2:0] {
    K_OTHER = 3'd0,
    K_QLOAD = 3'd1,
    K_QSTORE = 3'd2,
    K_QRESV = 3'd3,
    K_QCOND = 3'd4
  } kind_e;

  function automatic logic is_quad(logic [2:0] k);
    return (k == K_QLOAD) || (k == K_QSTORE) || (k == K_QRESV) || (k == K_QCOND);
  endfunction

  function automatic logic is_qload(logic [2:0] k);
    return (k == K_QLOAD) || (k == K_QRESV);
  endfunction
endpackage

// File: rtl/qw_screen.sv
// Legality and alignment screening of an incoming operation
module qw_screen #(
  parameter int REG_W = 5,
  parameter int ALIGN_BITS = 4
) (
  input  logic [2:0]            kind_i,
  input  logic [REG_W-1:0]      rt_i,
  input  logic [REG_W-1:0]      ra_i,
  input  logic [REG_W-1:0]      rb_i,
  input  logic [ALIGN_BITS-1:0] addr_lo_i,
  input  logic                  le_i,
  output logic                  illegal_o,
  output logic                  align_exc_o,
  output logic                  split_o
);
  import qw_pkg::*;

  logic overlap;
  logic misaligned;

  assign overlap    = (ra_i == rt_i) || (rb_i == rt_i);
  assign misaligned = |addr_lo_i;

  assign illegal_o   = (kind_i == K_QRESV) && overlap;
  assign align_exc_o = !illegal_o && le_i && is_qload(kind_i) && misaligned;
  assign split_o     = is_quad(kind_i) && !illegal_o && !align_exc_o;

  always_comb begin
    a_r7_flags_exclusive: assert ($onehot0({illegal_o, align_exc_o}));
  end
endmodule

// File: rtl/qw_seq.sv
// Two-phase sequencer: idle/first, then second
module qw_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  input  logic in_valid_i,
  input  logic split_i,
  input  logic out_ready_i,
  output logic in_ready_o,
  output logic out_valid_o,
  output logic second_o
);
  logic sec_q, sec_d;

  assign out_valid_o = !flush_i && (sec_q || in_valid_i);
  assign in_ready_o  = !flush_i && out_ready_i && (sec_q || !split_i);
  assign second_o    = sec_q;

  always_comb begin
    sec_d = sec_q;
    if (flush_i)                                     sec_d = 1'b0;
    else if (!sec_q && in_valid_i && split_i && out_ready_i) sec_d = 1'b1;
    else if (sec_q && out_ready_i)                   sec_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sec_q <= 1'b0;
    else         sec_q <= sec_d;
  end

  a_r9_hold_upstream: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sec_q && in_valid_i && split_i) |-> !in_ready_o);
  a_r10_flush_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !second_o);
endmodule

// File: rtl/qw_uop_gen.sv
// Builds register number and address for the current micro-op
module qw_uop_gen #(
  parameter int REG_W = 5,
  parameter int ADDR_W = 64,
  parameter int DW_BYTES = 8
) (
  input  logic [REG_W-1:0]  rt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              le_i,
  input  logic              split_i,
  input  logic              phase_i,
  output logic [REG_W-1:0]  rt_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              repeat_o,
  output logic              second_o,
  output logic              inhibit_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DW_BYTES);

  logic force_odd;
  assign force_odd = split_i && (le_i ^ phase_i);

  generate
    if (REG_W > 1) begin : g_wide
      assign rt_o = {rt_i[REG_W-1:1], rt_i[0] | force_odd};
    end else begin : g_narrow
      assign rt_o = rt_i | force_odd;
    end
  endgenerate

  assign addr_o    = (split_i && phase_i) ? addr_i + STEP : addr_i;
  assign repeat_o  = split_i;
  assign second_o  = split_i && phase_i;
  assign inhibit_o = split_i && phase_i;
endmodule

// File: rtl/qw_cracker.sv
module qw_cracker #(
  parameter int REG_W = 5,
  parameter int ADDR_W = 64,
  parameter int QW_BYTES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [2:0]        in_kind_i,
  input  logic [REG_W-1:0]  in_rt_i,
  input  logic [REG_W-1:0]  in_ra_i,
  input  logic [REG_W-1:0]  in_rb_i,
  input  logic [ADDR_W-1:0] in_addr_i,
  input  logic              in_le_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [2:0]        out_kind_o,
  output logic [REG_W-1:0]  out_rt_o,
  output logic [REG_W-1:0]  out_ra_o,
  output logic [REG_W-1:0]  out_rb_o,
  output logic [ADDR_W-1:0] out_addr_o,
  output logic              out_repeat_o,
  output logic              out_second_o,
  output logic              out_irq_inhibit_o,
  output logic              out_illegal_o,
  output logic              out_align_exc_o
);
  localparam int ALIGN_BITS = $clog2(QW_BYTES);
  localparam int DW_BYTES   = QW_BYTES / 2;

  logic split, illegal, align_exc, phase;

  qw_screen #(.REG_W(REG_W), .ALIGN_BITS(ALIGN_BITS)) u_screen (
    .kind_i(in_kind_i), .rt_i(in_rt_i), .ra_i(in_ra_i), .rb_i(in_rb_i),
    .addr_lo_i(in_addr_i[ALIGN_BITS-1:0]), .le_i(in_le_i),
    .illegal_o(illegal), .align_exc_o(align_exc), .split_o(split)
  );

  qw_seq u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i),
    .in_valid_i(in_valid_i), .split_i(split), .out_ready_i(out_ready_i),
    .in_ready_o(in_ready_o), .out_valid_o(out_valid_o), .second_o(phase)
  );

  qw_uop_gen #(.REG_W(REG_W), .ADDR_W(ADDR_W), .DW_BYTES(DW_BYTES)) u_gen (
    .rt_i(in_rt_i), .addr_i(in_addr_i), .le_i(in_le_i),
    .split_i(split), .phase_i(phase),
    .rt_o(out_rt_o), .addr_o(out_addr_o), .repeat_o(out_repeat_o),
    .second_o(out_second_o), .inhibit_o(out_irq_inhibit_o)
  );

  assign out_kind_o      = in_kind_i;
  assign out_ra_o        = in_ra_i;
  assign out_rb_o        = in_rb_i;
  assign out_illegal_o   = illegal;
  assign out_align_exc_o = align_exc;

  a_r2_second_has_repeat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_second_o) |-> out_repeat_o);
  a_r2_second_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && out_repeat_o && !out_second_o)
      |=> (flush_i || (out_valid_o && out_second_o)));
  a_r6_flagged_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && (out_illegal_o || out_align_exc_o)) |-> (!out_repeat_o && in_ready_o == out_ready_i));
  a_r3_same_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_repeat_o) |-> (out_rt_o[REG_W-1:1] == in_rt_i[REG_W-1:1]));
endmodule

// File: tb/qw_cracker_tb.sv
module qw_cracker_tb;
  logic clk = 0, rst_n = 0, flush = 0;
  logic in_valid = 0, out_ready = 1, le = 1;
  logic [2:0] kind = 0;
  logic [4:0] rt = 0, ra = 0, rb = 0;
  logic [63:0] addr = 0;
  logic in_ready, out_valid, rep, sec, inh, ill, aln;
  logic [2:0] okind;
  logic [4:0] ort, ora, orb;
  logic [63:0] oaddr;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  qw_cracker u_dut (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_kind_i(kind),
    .in_rt_i(rt), .in_ra_i(ra), .in_rb_i(rb), .in_addr_i(addr), .in_le_i(le),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_kind_o(okind),
    .out_rt_o(ort), .out_ra_o(ora), .out_rb_o(orb), .out_addr_o(oaddr),
    .out_repeat_o(rep), .out_second_o(sec), .out_irq_inhibit_o(inh),
    .out_illegal_o(ill), .out_align_exc_o(aln)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic offer(logic [2:0] k, logic [4:0] t, logic [4:0] a, logic [4:0] b,
                       logic [63:0] ad, logic e);
    @(negedge clk);
    kind = k; rt = t; ra = a; rb = b; addr = ad; le = e; in_valid = 1;
    #1;
  endtask

  task automatic idle_in();
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic t_reset();
    #1;
    chk("R11 valid idle", out_valid, 0);
    chk("R11 second idle", sec, 0);
  endtask

  task automatic t_pass();
    offer(3'd0, 5'd9, 5'd2, 5'd3, 64'h55, 1);
    chk("R1 valid", out_valid, 1);
    chk("R1 rt", ort, 9);
    chk("R1 addr", oaddr, 64'h55);
    chk("R1 ra", ora, 2);
    chk("R1 flags", {rep, sec, inh, ill, aln}, 0);
    chk("R1 ready", in_ready, 1);
    idle_in();
  endtask

  task automatic t_le_load();
    offer(3'd1, 5'd6, 5'd1, 5'd2, 64'h1000, 1);
    chk("R3 first rt", ort, 7);
    chk("R5 first addr", oaddr, 64'h1000);
    chk("R2 first rep/sec", {rep, sec}, 2'b10);
    chk("R8 first inhibit", inh, 0);
    chk("R9 ready low", in_ready, 0);
    @(negedge clk); #1;
    chk("R3 second rt", ort, 6);
    chk("R5 second addr", oaddr, 64'h1008);
    chk("R2 second rep/sec", {out_valid, rep, sec}, 3'b111);
    chk("R8 second inhibit", inh, 1);
    chk("R9 ready second", in_ready, 1);
    idle_in();
  endtask

  task automatic t_be_store();
    offer(3'd2, 5'd6, 5'd1, 5'd2, 64'h2008, 0);
    chk("R4 first rt", ort, 6);
    chk("R7 BE no align", {aln, rep}, 2'b01);
    @(negedge clk); #1;
    chk("R4 second rt", ort, 7);
    chk("R5 second addr", oaddr, 64'h2010);
    idle_in();
  endtask

  task automatic t_illegal();
    offer(3'd3, 5'd4, 5'd4, 5'd2, 64'h3000, 1);
    chk("R6 illegal ra", {ill, rep, in_ready}, 3'b101);
    @(negedge clk); kind = 3'd3; rt = 4; ra = 1; rb = 4; #1;
    chk("R6 illegal rb", {ill, rep, sec}, 3'b100);
    @(negedge clk); kind = 3'd3; rt = 4; ra = 1; rb = 2; addr = 64'h3004; #1;
    chk("R7 reserve misaligned", {ill, aln, rep}, 3'b010);
    @(negedge clk); rb = 4; #1;
    chk("R6 priority over R7", {ill, aln}, 2'b10);
    idle_in();
  endtask

  task automatic t_align();
    offer(3'd1, 5'd8, 5'd1, 5'd2, 64'h1008, 1);
    chk("R7 LE misaligned load", {aln, rep, in_ready}, 3'b101);
    @(negedge clk); kind = 3'd4; #1;
    chk("R7 store no check", {aln, rep}, 2'b01);
    idle_in();
  endtask

  task automatic t_backpressure();
    @(negedge clk); out_ready = 0;
    offer(3'd1, 5'd10, 5'd1, 5'd2, 64'h4000, 1);
    @(negedge clk); #1;
    chk("R9 held first", {out_valid, sec, in_ready}, 3'b100);
    chk("R3 held rt", ort, 11);
    out_ready = 1;
    @(negedge clk); #1;
    chk("R2 second after release", sec, 1);
    idle_in();
  endtask

  task automatic t_flush();
    offer(3'd1, 5'd12, 5'd1, 5'd2, 64'h5000, 1);
    @(negedge clk); flush = 1; #1;
    chk("R10 flush valid", {out_valid, in_ready}, 2'b00);
    @(negedge clk); flush = 0; #1;
    chk("R10 refirst", {out_valid, sec}, 2'b10);
    chk("R10 refirst rt", ort, 13);
    @(negedge clk); #1;
    chk("R10 then second", sec, 1);
    idle_in();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    #20 rst_n = 1;
    t_reset();
    t_pass();
    t_le_load();
    t_be_store();
    t_illegal();
    t_align();
    t_backpressure();
    t_flush();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule